// File: doc/BRIEF.md
# Line-Change Timestamping Engine

This block watches a wide set of asynchronous signal lines and writes a record into an on-chip queue whenever an enabled line changes level. Each record holds three things: the value of a free-running 64-bit system time input, taken when the change is accepted, the index of the line that changed, and the new level of that line. Software chooses which lines are monitored by writing 32-bit enable words, one word for each group of 32 lines. It drains the queue through a small register interface, where a read of the event word removes the head record.

When several lines change in the same cycle, they form one batch. The records of a batch go into the queue in ascending line order, and all of them carry the same time value. An interrupt output goes high while the queue holds at least a programmable number of records. Records that arrive while the queue is full are discarded, and a sticky status flag records that this happened.

Top module: `evt_stamp`

## Requirements
- R1: Each line passes through two synchronising flops. When a change occurs on an enabled line while no batch is draining, the block queues one record. The record's time equals the `sys_time` value sampled on the third rising clock edge after the change.
- R2: Records are read at these addresses:
  - Address 2 gives bits 31:0 of the head record's time, and address 3 gives bits 63:32.
  - Address 4 gives the event word: bit 31 is 1 when a record is present, bit 16 is the new level (1 for a rise, 0 for a fall), and bits 15:0 are the line index.
- R3: Lines that change in the same cycle are queued in ascending index order, and every record of that batch carries the same time value.
- R4: The enable word for lines 32s to 32s+31 sits at address 8+s, with bit b controlling line 32s+b. The word reads back as written, and a line whose bit is 0 produces no record.
- R5: Enabling a line whose level already differs from its level at reset produces no record.
- R6: Records leave the queue in arrival order, one per read of address 4 while bit 31 is set. A read of address 4 on an empty queue returns bit 31 = 0 and leaves the occupancy at 0.
- R7: A record that arrives while the queue holds DEPTH entries is discarded, and bit 16 of address 1 is set. Writing 1 to that bit clears it; writing 0 leaves it set.
- R8: Bits 15:0 of address 1 give the current number of queued records.
- R9: `irq` is high while occupancy is at or above the threshold and low once occupancy falls below it. The threshold sits in bits 8:0 of address 0 and resets to 1. A write of 0 stores 1, and a write above 256 stores 256.
- R10: After reset, the queue is empty, all enable words are 0, the threshold is 1, the overflow flag is 0 and `irq` is 0.
- R11: `rd_data` is registered. It shows the register addressed at the previous rising edge with `rd_en` high, and keeps its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | SLICES*32 | Asynchronous monitored lines |
| sys_time | input | 64 | Free-running system time |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 8 | Read address |
| rd_data | output | 32 | Registered read data |
| irq | output | 1 | Occupancy-threshold interrupt |

## Verification
The engine is driven with single rising and falling changes, which separate the level bit and the three-edge sampling point. Three lines far apart change in one cycle, which exposes a wrong drain order or a batch carrying more than one time value. Lines that are disabled, and lines that are enabled while already high, show whether the enable mask and the reference level are handled correctly. A burst of changes deeper than the queue, along with reads on an empty queue, exercises occupancy, the discard path, the sticky flag's clear rule and the threshold crossing in both directions.

// File: rtl/evt_stamp_pkg.sv
package evt_stamp_pkg;
  localparam int TS_W = 64;
  localparam logic [7:0] A_THR    = 8'd0;
  localparam logic [7:0] A_STATUS = 8'd1;
  localparam logic [7:0] A_TSLO   = 8'd2;
  localparam logic [7:0] A_TSHI   = 8'd3;
  localparam logic [7:0] A_EVENT  = 8'd4;
  localparam logic [7:0] A_EN     = 8'd8;
  localparam int OVF_BIT = 16;
endpackage

// File: rtl/evt_sync_detect.sv
module evt_sync_detect #(
  parameter int NL = 96
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NL-1:0] line_in,
  input  logic [NL-1:0] en,
  input  logic          accept,
  output logic [NL-1:0] chg,
  output logic [NL-1:0] lvl
);
  logic [NL-1:0] s1_q, s2_q, ref_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q  <= '0;
      s2_q  <= '0;
      ref_q <= '0;
    end else begin
      s1_q <= line_in;
      s2_q <= s1_q;
      // disabled lines track their level so enabling them is silent
      if (accept) ref_q <= s2_q;
      else        ref_q <= (ref_q & en) | (s2_q & ~en);
    end
  end

  assign chg = en & (s2_q ^ ref_q);
  assign lvl = s2_q;
endmodule

// File: rtl/evt_batch.sv
module evt_batch #(
  parameter int NL   = 96,
  parameter int IW   = 7,
  parameter int TS_W = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NL-1:0]   chg,
  input  logic [NL-1:0]   lvl,
  input  logic [TS_W-1:0] sys_time,
  output logic            accept,
  output logic            busy,
  output logic            push,
  output logic [IW-1:0]   push_idx,
  output logic            push_lvl,
  output logic [TS_W-1:0] push_ts
);
  logic [NL-1:0]   pend_q, lvl_q, sel_oh;
  logic [TS_W-1:0] ts_q;
  logic [IW-1:0]   sel_idx;

  assign busy   = |pend_q;
  assign accept = !busy && (|chg);

  // lowest pending line wins
  always_comb begin
    sel_idx = '0;
    for (int i = NL - 1; i >= 0; i--) begin
      if (pend_q[i]) sel_idx = IW'(i);
    end
  end
  assign sel_oh = pend_q & (~pend_q + NL'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      lvl_q  <= '0;
      ts_q   <= '0;
    end else if (accept) begin
      pend_q <= chg;
      lvl_q  <= lvl;
      ts_q   <= sys_time;
    end else begin
      pend_q <= pend_q & ~sel_oh;
    end
  end

  assign push     = busy;
  assign push_idx = sel_idx;
  assign push_lvl = lvl_q[sel_idx];
  assign push_ts  = ts_q;
endmodule

// File: rtl/evt_fifo.sv
module evt_fifo #(
  parameter int EW    = 72,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [EW-1:0] din,
  input  logic          pop,
  output logic [EW-1:0] head,
  output logic          head_valid,
  output logic [CW-1:0] count,
  output logic          full
);
  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q, rp_nxt;
  logic [CW-1:0] cnt_nxt;
  logic          wr, rd;

  assign full    = (count == CW'(DEPTH));
  assign wr      = push && !full;
  assign rd      = pop && (count != '0);
  assign rp_nxt  = rd ? rp_q + AW'(1) : rp_q;
  assign cnt_nxt = count + CW'(wr) - CW'(rd);

  always_ff @(posedge clk) begin
    if (wr) mem[wp_q] <= din;
    head <= mem[rp_nxt];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q       <= '0;
      rp_q       <= '0;
      count      <= '0;
      head_valid <= 1'b0;
    end else begin
      if (wr) wp_q <= wp_q + AW'(1);
      rp_q       <= rp_nxt;
      count      <= cnt_nxt;
      // head is stale for one cycle when written at the read address
      head_valid <= (cnt_nxt != '0) && !(wr && (wp_q == rp_nxt));
    end
  end
endmodule

// File: rtl/evt_stamp.sv
module evt_stamp
  import evt_stamp_pkg::*;
#(
  parameter int SLICES = 3,
  parameter int DEPTH  = 256
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [SLICES*32-1:0] line_in,
  input  logic [63:0]          sys_time,
  input  logic                 wr_en,
  input  logic [7:0]           wr_addr,
  input  logic [31:0]          wr_data,
  input  logic                 rd_en,
  input  logic [7:0]           rd_addr,
  output logic [31:0]          rd_data,
  output logic                 irq
);
  localparam int NL = SLICES * 32;
  localparam int IW = $clog2(NL);
  localparam int EW = TS_W + 1 + IW;
  localparam int CW = $clog2(DEPTH + 1);

  logic [NL-1:0]   en_q, chg, lvl;
  logic            accept, batch_busy, push, push_lvl;
  logic [IW-1:0]   push_idx;
  logic [TS_W-1:0] push_ts;
  logic [EW-1:0]   head;
  logic            head_valid, full, pop, ovf_q, ovf_clr;
  logic [CW-1:0]   count;
  logic [15:0]     cnt16;
  logic [8:0]      thr_q, thr_in;
  logic [31:0]     rd_mux;

  evt_sync_detect #(.NL(NL)) u_sync (
    .clk(clk), .rst(rst), .line_in(line_in), .en(en_q),
    .accept(accept), .chg(chg), .lvl(lvl)
  );

  evt_batch #(.NL(NL), .IW(IW), .TS_W(TS_W)) u_batch (
    .clk(clk), .rst(rst), .chg(chg), .lvl(lvl), .sys_time(sys_time),
    .accept(accept), .busy(batch_busy), .push(push),
    .push_idx(push_idx), .push_lvl(push_lvl), .push_ts(push_ts)
  );

  evt_fifo #(.EW(EW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(push), .din({push_ts, push_lvl, push_idx}),
    .pop(pop), .head(head), .head_valid(head_valid), .count(count), .full(full)
  );

  assign cnt16   = 16'(count);
  assign pop     = rd_en && (rd_addr == A_EVENT) && head_valid;
  assign ovf_clr = wr_en && (wr_addr == A_STATUS) && wr_data[OVF_BIT];

  always_comb begin
    if (wr_data == 32'd0)        thr_in = 9'd1;
    else if (wr_data > 32'd256)  thr_in = 9'd256;
    else                         thr_in = wr_data[8:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      thr_q <= 9'd1;
      ovf_q <= 1'b0;
      irq   <= 1'b0;
    end else begin
      for (int s = 0; s < SLICES; s++) begin
        if (wr_en && (wr_addr == A_EN + 8'(s))) en_q[s*32 +: 32] <= wr_data;
      end
      if (wr_en && (wr_addr == A_THR)) thr_q <= thr_in;
      if (push && full)  ovf_q <= 1'b1;
      else if (ovf_clr)  ovf_q <= 1'b0;
      irq <= (cnt16 >= 16'(thr_q));
    end
  end

  always_comb begin
    rd_mux = '0;
    case (rd_addr)
      A_THR:    rd_mux = {23'd0, thr_q};
      A_STATUS: rd_mux = {15'd0, ovf_q, cnt16};
      A_TSLO:   rd_mux = head[IW+1 +: 32];
      A_TSHI:   rd_mux = head[IW+33 +: 32];
      A_EVENT:  rd_mux = {head_valid, 14'd0, head[IW], 16'(head[IW-1:0])};
      default: begin
        for (int s = 0; s < SLICES; s++) begin
          if (rd_addr == A_EN + 8'(s)) rd_mux = en_q[s*32 +: 32];
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end
endmodule

// File: rtl/evt_stamp_sva.sv
module evt_stamp_sva #(
  parameter int DEPTH = 256
) (
  input logic        clk,
  input logic        rst,
  input logic        ovf_q,
  input logic        ovf_clr,
  input logic        push,
  input logic        full,
  input logic [15:0] cnt16,
  input logic        irq,
  input logic        head_valid,
  input logic        batch_busy,
  input logic [63:0] push_ts
);
  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    ovf_q && !ovf_clr |=> ovf_q);

  assert_drop_flags_R7: assert property (@(posedge clk) disable iff (rst)
    push && full |=> ovf_q);

  assert_count_bound_R8: assert property (@(posedge clk) disable iff (rst)
    cnt16 <= 16'(DEPTH));

  assert_irq_needs_entries_R9: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(cnt16) != 16'd0);

  assert_empty_stays_R6: assert property (@(posedge clk) disable iff (rst)
    cnt16 == 16'd0 && !push |=> cnt16 == 16'd0);

  assert_head_nonempty_R6: assert property (@(posedge clk) disable iff (rst)
    head_valid |-> cnt16 != 16'd0);

  assert_batch_one_stamp_R3: assert property (@(posedge clk) disable iff (rst)
    batch_busy && $past(batch_busy) |-> $stable(push_ts));
endmodule

bind evt_stamp evt_stamp_sva #(.DEPTH(DEPTH)) u_sva (
  .clk(clk), .rst(rst), .ovf_q(ovf_q), .ovf_clr(ovf_clr), .push(push),
  .full(full), .cnt16(cnt16), .irq(irq), .head_valid(head_valid),
  .batch_busy(batch_busy), .push_ts(push_ts)
);

// File: tb/evt_stamp_tb.sv
module evt_stamp_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SLICES = 3;
  localparam int DEPTH  = 8;
  localparam int NL     = SLICES * 32;

  typedef struct packed {
    logic [63:0] ts;
    logic        lv;
    logic [15:0] idx;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NL-1:0] lines = '0;
  logic [63:0] tcnt;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic irq;

  int n_chk = 0, n_fail = 0;
  exp_t exp_q[$];
  logic [NL-1:0] en_m = '0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  always_ff @(posedge clk) begin
    if (rst) tcnt <= 64'h0000_0001_FFFF_FF00;
    else     tcnt <= tcnt + 64'd1;
  end

  evt_stamp #(.SLICES(SLICES), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .line_in(lines), .sys_time(tcnt),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
    if (a >= 8'd8 && a < 8'd8 + 8'(SLICES)) en_m[(a - 8'd8) * 32 +: 32] = d;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; rd_addr = a;
    @(negedge clk); d = rd_data; rd_en = 1'b0;
  endtask

  // driver: changes lines and predicts the records
  task automatic toggle(input logic [NL-1:0] m);
    @(negedge clk);
    for (int i = 0; i < NL; i++) begin
      if (m[i] && en_m[i] && exp_q.size() < DEPTH)
        exp_q.push_back({tcnt + 64'd2, ~lines[i], 16'(i)});
    end
    lines = lines ^ m;
    repeat (8) @(negedge clk);
  endtask

  // monitor: pops one record and compares it against the scoreboard
  task automatic pop_check(input string tag, output bit got);
    logic [31:0] lo, hi, ev;
    exp_t e;
    rd(8'd2, lo); rd(8'd3, hi); rd(8'd4, ev);
    got = ev[31];
    if (!got) return;
    if (exp_q.size() == 0) begin
      chk(1'b0, {tag, " unexpected record"}, 64'(ev), 64'd0);
      return;
    end
    e = exp_q.pop_front();
    chk({hi, lo} == e.ts, {tag, " stamp"}, {hi, lo}, e.ts);
    chk(ev[15:0] == e.idx, {tag, " index"}, 64'(ev[15:0]), 64'(e.idx));
    chk(ev[16] == e.lv, {tag, " level"}, 64'(ev[16]), 64'(e.lv));
  endtask

  task automatic drain(input string tag);
    bit got;
    for (int k = 0; k < 4 * DEPTH; k++) begin
      pop_check(tag, got);
      if (!got) break;
    end
    chk(exp_q.size() == 0, {tag, " records missing"}, 64'(exp_q.size()), 64'd0);
  endtask

  function automatic logic [NL-1:0] bit_at(input int i);
    logic [NL-1:0] m = '0;
    m[i] = 1'b1;
    return m;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d, prev;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R10 reset state
    rd(8'd1, d);  chk(d == 32'd0, "R10 status", 64'(d), 64'd0);
    rd(8'd0, d);  chk(d == 32'd1, "R10 threshold", 64'(d), 64'd1);
    rd(8'd4, d);  chk(d[31] == 1'b0, "R10 queue empty", 64'(d[31]), 64'd0);
    rd(8'd8, d);  chk(d == 32'd0, "R10 enable word", 64'(d), 64'd0);
    chk(irq == 1'b0, "R10 irq", 64'(irq), 64'd0);

    // R5: line 3 rises while disabled, then it is enabled
    toggle(bit_at(3));
    wr(8'd8, 32'hFFFF_FFFF);
    wr(8'd9, 32'h0000_0001);
    wr(8'd10, 32'h8000_0000);
    rd(8'd9, d); chk(d == 32'h1, "R4 enable readback", 64'(d), 64'h1);
    repeat (6) @(negedge clk);
    rd(8'd1, d); chk(d[15:0] == 16'd0, "R5 no event on enable", 64'(d[15:0]), 64'd0);

    // R4: disabled line 40
    toggle(bit_at(40));
    rd(8'd1, d); chk(d[15:0] == 16'd0, "R4 disabled line ignored", 64'(d[15:0]), 64'd0);

    // R1/R2: single rising change
    toggle(bit_at(5));
    rd(8'd1, d); chk(d[15:0] == 16'd1, "R8 occupancy one", 64'(d[15:0]), 64'd1);
    drain("R1 single rise");

    // R3: simultaneous changes on 95, 32 and 7
    toggle(bit_at(95) | bit_at(32) | bit_at(7));
    drain("R3 batch order");
    toggle(bit_at(7));
    drain("R2 falling");

    // R9: threshold interrupt
    wr(8'd0, 32'd3);
    toggle(bit_at(0));
    toggle(bit_at(1));
    rd(8'd1, d); chk(d[15:0] == 16'd2, "R8 occupancy two", 64'(d[15:0]), 64'd2);
    chk(irq == 1'b0, "R9 below threshold", 64'(irq), 64'd0);
    toggle(bit_at(2));
    chk(irq == 1'b1, "R9 at threshold", 64'(irq), 64'd1);
    begin
      bit got;
      pop_check("R6 single pop", got);
    end
    repeat (2) @(negedge clk);
    chk(irq == 1'b0, "R9 falls below", 64'(irq), 64'd0);
    drain("R6 rest");
    wr(8'd0, 32'd0);   rd(8'd0, d); chk(d == 32'd1, "R9 zero clamps", 64'(d), 64'd1);
    wr(8'd0, 32'd300); rd(8'd0, d); chk(d == 32'd256, "R9 high clamps", 64'(d), 64'd256);
    wr(8'd0, 32'd8);

    // R7: overflow with ten changes into an eight-deep queue
    for (int k = 0; k < 10; k++) toggle(bit_at(0));
    rd(8'd1, d);
    chk(d[15:0] == 16'(DEPTH), "R8 occupancy full", 64'(d[15:0]), 64'(DEPTH));
    chk(d[16] == 1'b1, "R7 overflow set", 64'(d[16]), 64'd1);
    chk(irq == 1'b1, "R9 full at threshold 8", 64'(irq), 64'd1);
    wr(8'd1, 32'd0);
    rd(8'd1, d); chk(d[16] == 1'b1, "R7 write 0 keeps flag", 64'(d[16]), 64'd1);
    wr(8'd1, 32'h0001_0000);
    rd(8'd1, d); chk(d[16] == 1'b0, "R7 write 1 clears flag", 64'(d[16]), 64'd0);
    drain("R6 order after overflow");

    // R6: reads on an empty queue
    rd(8'd4, d); chk(d[31] == 1'b0, "R6 empty valid", 64'(d[31]), 64'd0);
    rd(8'd1, d); chk(d[15:0] == 16'd0, "R6 empty occupancy", 64'(d[15:0]), 64'd0);

    // R11: registered read data
    rd(8'd1, prev);
    @(negedge clk); rd_en = 1'b1; rd_addr = 8'd0;
    #1 chk(rd_data == prev, "R11 holds before edge", 64'(rd_data), 64'(prev));
    @(negedge clk); rd_en = 1'b0;
    chk(rd_data == 32'd8, "R11 updates after edge", 64'(rd_data), 64'd8);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule